// File: doc/BRIEF.md
# Basic Interval Timer with Buffered Prescaler

This block is a 16-bit up-counting interval timer reached through a small register port. A prescaler divides the timer clock. The counter steps once per divided tick, runs from zero to the period value inclusive, and then returns to zero. When it returns to zero it raises an update event, and that event can set a sticky overflow flag and drive an interrupt line.

A new prescaler value written by software waits in a buffer. It becomes the active divider only when an update event occurs. Software can force an update event through a self-clearing command bit, and a trigger input can force one too. A forced event reinitializes the counter and the internal divider count. A source-select bit decides whether forced events set the flag or only natural wraps do. A block bit suppresses update events entirely.

The register port carries no data stream and has no back-pressure. Every request with `reg_valid` high is accepted in that cycle, and a write takes effect at the next clock edge. Read data is combinational from `reg_addr`. The register map is as follows:
- Offset 0 is control: bit0 run, bit1 update block, bit2 counter-only source, bit3 interrupt enable.
- Offset 1 is status: bit0 is the flag.
- Offset 2 is the event command: bit0 forces an event.
- Offset 3 is the counter.
- Offset 4 is the prescaler buffer.
- Offset 5 is the period.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, status, counter, prescaler and period registers read 0x0000, and `ovf_irq` and `upd_pulse` are 0.
- R2: While control bit0 is 1 and the period is nonzero, the counter steps 0,1,..,period. On the next tick it returns to 0, the flag (status bit0) is set, and `upd_pulse` is high for exactly one cycle.
- R3: With active prescaler value D, the counter advances once every D+1 clocks. After n clocks from a zeroed start it reads floor(n/(D+1)) mod (period+1).
- R4: A write to offset 4 fills only the buffer, and reads of offset 4 return the buffer. The buffer moves into the active divider only at an update event.
- R5: When the period is 0, the counter does not change, except through a counter write or a forced event.
- R6: Writing 1 to bit0 of offset 2 forces an update event. In that edge the counter and the divider count become 0, and the active divider is reloaded. Writing 0 does nothing, and offset 2 always reads 0.
- R7: A cycle with `trig_in` high forces an update event with the same effects as R6.
- R8: With control bit2 at 1, forced events (R6, R7) still clear the counter and reload the divider, but they do not set the flag. Natural wraps still set it.
- R9: With control bit1 at 1, no update event occurs. A wrap returns the counter to 0 without setting the flag and without reloading the divider, and forced events have no effect.
- R10: The flag stays set until a write to offset 1 with bit0 at 0 clears it. `ovf_irq` equals the flag AND control bit3.
- R11: A write to offset 3 loads the counter at the next edge and resets the divider count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register request valid, always accepted |
| reg_write | input | 1 | 1 = write request |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| trig_in | input | 1 | Counter reinitialize trigger, active high |
| upd_pulse | output | 1 | One-cycle pulse after each update event |
| ovf_irq | output | 1 | Interrupt: flag AND interrupt enable |

## Verification
The counting function is driven in several ways:
- With a zero and a nonzero divider over short periods, sampled at a known number of clocks after start. This separates off-by-one errors in the inclusive period from errors in the divide ratio.
- With a prescaler written mid-run. This shows whether the buffer leaks into the active divider before a wrap.
- With software and trigger events under each source setting, and under the update block. These separate "clears the counter" from "sets the flag" from "reloads the divider".
- With a counter write and a zero period. These cover the reload and halt paths.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_EVT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd4;
  localparam logic [ADDR_W-1:0] A_PER   = 3'd5;

  typedef struct packed {
    logic irq_en;
    logic src_cnt_only;
    logic upd_block;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_ok,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         tick,
  output logic [W-1:0] active
);
  logic [W-1:0] div_cnt;

  assign tick = run_ok && !clear && (div_cnt == active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= '0;
      div_cnt <= '0;
    end else begin
      if (load) active <= load_val;
      if (clear) div_cnt <= '0;
      else if (run_ok) div_cnt <= (div_cnt == active) ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = tick && (cnt >= period);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_en)  cnt <= wr_val;
    else if (clear)  cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  input  logic              flag_set,
  input  logic [W-1:0]      cnt,
  output ctrl_t             ctrl,
  output logic [W-1:0]      presc_buf,
  output logic [W-1:0]      period,
  output logic              flag,
  output logic              cnt_wr,
  output logic              sw_evt,
  output logic [W-1:0]      rdata
);
  logic wr;
  logic flag_clr;

  assign wr       = req_valid && req_write;
  assign cnt_wr   = wr && (req_addr == A_COUNT);
  assign sw_evt   = wr && (req_addr == A_EVT) && req_wdata[0];
  assign flag_clr = wr && (req_addr == A_STAT) && !req_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      presc_buf <= '0;
      period    <= '0;
      flag      <= 1'b0;
    end else begin
      if (wr && req_addr == A_CTRL)  ctrl      <= ctrl_t'(req_wdata[CTRL_W-1:0]);
      if (wr && req_addr == A_PRESC) presc_buf <= req_wdata;
      if (wr && req_addr == A_PER)   period    <= req_wdata;
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (req_addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl;
      A_STAT:  rdata[0]          = flag;
      A_COUNT: rdata             = cnt;
      A_PRESC: rdata             = presc_buf;
      A_PER:   rdata             = period;
      default: rdata             = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              trig_in,
  output logic              upd_pulse,
  output logic              ovf_irq
);
  ctrl_t        ctrl_q;
  logic [W-1:0] presc_buf, period_q, cnt_q, presc_act;
  logic         flag_q, cnt_wr, sw_evt;
  logic         run_ok, tick, wrap, forced_eff, upd_evt, flag_set;
  logic         upd_en, src_only, irq_en;

  assign upd_en     = !ctrl_q.upd_block;
  assign src_only   = ctrl_q.src_cnt_only;
  assign irq_en     = ctrl_q.irq_en;
  assign run_ok     = ctrl_q.run && (period_q != '0);
  assign forced_eff = upd_en && (sw_evt || trig_in);
  assign upd_evt    = (upd_en && wrap) || forced_eff;
  assign flag_set   = (upd_en && wrap) || (forced_eff && !src_only);

  tt_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(reg_valid), .req_write(reg_write), .req_addr(reg_addr),
    .req_wdata(reg_wdata), .flag_set(flag_set), .cnt(cnt_q),
    .ctrl(ctrl_q), .presc_buf(presc_buf), .period(period_q), .flag(flag_q),
    .cnt_wr(cnt_wr), .sw_evt(sw_evt), .rdata(reg_rdata)
  );

  tt_prescaler #(.W(W)) presc_i (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok),
    .clear(forced_eff || cnt_wr), .load(upd_evt), .load_val(presc_buf),
    .tick(tick), .active(presc_act)
  );

  tt_counter #(.W(W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(forced_eff),
    .wr_en(cnt_wr), .wr_val(reg_wdata), .period(period_q),
    .cnt(cnt_q), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= upd_evt;
  end

  assign ovf_irq = flag_q && irq_en;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic         flag,
  input logic         upd_pulse,
  input logic         cnt_wr,
  input logic         forced,
  input logic         src_only,
  input logic         upd_block,
  input logic         sw_evt,
  input logic         trig_in,
  input logic         reg_valid,
  input logic         reg_write,
  input logic [2:0]   reg_addr
);
  logic stat_wr;
  assign stat_wr = reg_valid && reg_write && (reg_addr == 3'd1);

  AST_ZERO_PERIOD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && !cnt_wr && !forced) |=> $stable(cnt)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stat_wr) |=> flag); // R10

  AST_PULSE_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && (forced || (period != '0 && cnt > period))) |=> (cnt == '0 || upd_pulse)); // R2

  AST_FLAG_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> upd_pulse); // R2

  AST_SRC_ONLY_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (src_only && forced && !flag) |=> !flag); // R8

  AST_BLOCK_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_block && !cnt_wr) |=> !upd_pulse); // R9

  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_block && (sw_evt || trig_in) && !cnt_wr) |=> (cnt == '0)); // R6 R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !forced) |=> ($stable(cnt) || cnt == '0 || cnt == W'($past(cnt) + 1'b1))); // R3
endmodule

bind tick_timer tick_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .period(period_q), .flag(flag_q),
  .upd_pulse(upd_pulse), .cnt_wr(cnt_wr), .forced(forced_eff),
  .src_only(src_only), .upd_block(!upd_en), .sw_evt(sw_evt), .trig_in(trig_in),
  .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0, trig_in = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic upd_pulse, ovf_irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_in(trig_in), .upd_pulse(upd_pulse), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #0.2;
    v = int'(reg_rdata);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", int'(ovf_irq), 0);
    chk("R1 pulse", int'(upd_pulse), 0);
  endtask

  task automatic t_basic();
    int v;
    do_reset();
    wr(3'd5, 16'd4);
    wr(3'd0, 16'd1);
    step(3); rd(3'd3, v); chk("R2 cnt@3", v, 3);
    step(1); rd(3'd3, v); chk("R2 cnt@4 inclusive", v, 4);
    rd(3'd1, v); chk("R2 no flag before wrap", v, 0);
    step(1); rd(3'd3, v); chk("R2 wrap to 0", v, 0);
    rd(3'd1, v); chk("R2 flag", v, 1);
    chk("R2 pulse high", int'(upd_pulse), 1);
    chk("R10 irq masked", int'(ovf_irq), 0);
    step(1); chk("R2 pulse one cycle", int'(upd_pulse), 0);
    step(3); rd(3'd1, v); chk("R10 flag sticky", v, 1);
    wr(3'd0, 16'h9);
    chk("R10 irq", int'(ovf_irq), 1);
    wr(3'd1, 16'd0);
    rd(3'd1, v); chk("R10 flag cleared", v, 0);
    chk("R10 irq low", int'(ovf_irq), 0);
  endtask

  task automatic t_prescale();
    int v;
    do_reset();
    wr(3'd4, 16'd2);
    rd(3'd4, v); chk("R4 readback", v, 2);
    wr(3'd2, 16'd1);
    rd(3'd1, v); chk("R6 flag any", v, 1);
    wr(3'd1, 16'd0);
    wr(3'd5, 16'd2);
    wr(3'd0, 16'd1);
    step(7); rd(3'd3, v); chk("R3 cnt@7 div3", v, 2);
    rd(3'd1, v); chk("R3 no flag yet", v, 0);
    step(2); rd(3'd3, v); chk("R3 cnt@9 wrapped", v, 0);
    rd(3'd1, v); chk("R3 flag", v, 1);
  endtask

  task automatic t_shadow();
    int v;
    do_reset();
    wr(3'd5, 16'd100);
    wr(3'd0, 16'd1);
    step(2);
    wr(3'd4, 16'd3);
    step(2); rd(3'd3, v); chk("R4 buffer not active", v, 5);
    wr(3'd3, 16'd100);
    rd(3'd3, v); chk("R11 count loaded", v, 100);
    step(1); rd(3'd3, v); chk("R11 tick after write", v, 0);
    step(3); rd(3'd3, v); chk("R4 new div active", v, 0);
    step(1); rd(3'd3, v); chk("R4 div4 step", v, 1);
  endtask

  task automatic t_zero_period();
    int v;
    do_reset();
    wr(3'd0, 16'd1);
    step(10); rd(3'd3, v); chk("R5 halted", v, 0);
    wr(3'd3, 16'd5);
    step(6); rd(3'd3, v); chk("R5 holds written", v, 5);
    rd(3'd1, v); chk("R5 no flag", v, 0);
  endtask

  task automatic t_sw_event();
    int v;
    do_reset();
    wr(3'd5, 16'd50);
    wr(3'd0, 16'd1);
    step(5); rd(3'd3, v); chk("R6 pre cnt", v, 5);
    wr(3'd2, 16'd0);
    rd(3'd3, v); chk("R6 write 0 no effect", v, 6);
    rd(3'd1, v); chk("R6 write 0 no flag", v, 0);
    wr(3'd2, 16'd1);
    rd(3'd3, v); chk("R6 cleared", v, 0);
    rd(3'd1, v); chk("R6 flag", v, 1);
    rd(3'd2, v); chk("R6 reads 0", v, 0);
    step(2); rd(3'd3, v); chk("R6 resumes", v, 2);
  endtask

  task automatic t_trigger();
    int v;
    do_reset();
    wr(3'd5, 16'd50);
    wr(3'd0, 16'd1);
    step(4);
    trig_in = 1'b1; step(1); trig_in = 1'b0;
    rd(3'd3, v); chk("R7 cleared", v, 0);
    rd(3'd1, v); chk("R7 flag", v, 1);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd5);
    trig_in = 1'b1; step(1); trig_in = 1'b0;
    rd(3'd3, v); chk("R8 trig clears", v, 0);
    rd(3'd1, v); chk("R8 trig no flag", v, 0);
  endtask

  task automatic t_src_only();
    int v;
    do_reset();
    wr(3'd4, 16'd1);
    wr(3'd0, 16'd4);
    wr(3'd2, 16'd1);
    rd(3'd1, v); chk("R8 sw no flag", v, 0);
    wr(3'd5, 16'd1);
    wr(3'd0, 16'd5);
    step(3); rd(3'd3, v); chk("R8 div reloaded", v, 1);
    step(1); rd(3'd3, v); chk("R8 wrap", v, 0);
    rd(3'd1, v); chk("R8 natural wrap flags", v, 1);
  endtask

  task automatic t_block();
    int v;
    do_reset();
    wr(3'd4, 16'd2);
    wr(3'd5, 16'd2);
    wr(3'd0, 16'd3);
    step(2); rd(3'd3, v); chk("R9 cnt", v, 2);
    step(1); rd(3'd3, v); chk("R9 wraps", v, 0);
    rd(3'd1, v); chk("R9 no flag", v, 0);
    chk("R9 no pulse", int'(upd_pulse), 0);
    step(1); rd(3'd3, v); chk("R9 no div reload", v, 1);
    wr(3'd2, 16'd1);
    rd(3'd3, v); chk("R9 sw ignored", v, 2);
    rd(3'd1, v); chk("R9 sw no flag", v, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_basic();
    t_prescale();
    t_shadow();
    t_zero_period();
    t_sw_event();
    t_trigger();
    t_src_only();
    t_block();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule